// File: doc/BRIEF.md
# Serial Receiver with Three-Entry Character Queue

This block turns an asynchronous serial line into parallel characters. A free-running enable that pulses sixteen times per bit period paces it. After a falling edge the line is checked again half a bit later, and a start is accepted only if the line is still low. Data bits are then taken at the centre of each bit cell, least significant bit first. The character holds between five and eight data bits, may carry a parity bit, and ends with one stop bit.

Each finished character goes into a three-entry first-in first-out queue, together with its own parity, framing and overrun flags. The host reads the oldest character with a one-cycle read strobe, and that character's flags leave the queue with it. Readiness and fullness outputs give the queue state. One configuration input picks which of the two drives the interrupt line. An active-low request-to-send output can be set to withdraw permission automatically while the queue is full.

Top module: `serial_rx_queue`

## Requirements
- R1: Characters leave the queue in arrival order, and the queue holds at most three characters.
- R2: `rxReady` is 1 exactly when at least one character is queued.
- R3: `queueFull` is 1 exactly when three characters are queued.
- R4: `rxIrq` follows `queueFull` when `intSelFull` is 1, and follows `rxReady` when it is 0.
- R5: A cycle with `rdStrobe` high and `rxReady` high removes the head entry. `rdData`, `rdParErr`, `rdFrmErr` and `rdOvrErr` always show the head entry, and all read 0 while the queue is empty.
- R6: `charLenSel` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The first bit received lands in `rdData[0]`, and the unused upper bits read 0.
- R7: With `parityOn` set, one parity bit follows the data. It is even parity when `parityOdd` is 0 and odd parity when it is 1, and a mismatch sets that character's `rdParErr`. With `parityOn` clear, no parity bit is expected and `rdParErr` stays 0.
- R8: A stop bit sampled low sets that character's `rdFrmErr`, and the character is still stored.
- R9: A character that completes while the queue is full (and no read happens in that cycle) is discarded. The newest queued entry gets its overrun flag set, and the queued data are left unchanged.
- R10: `rtsN` is 1 while `autoRtsOn` is 1 and the queue is full; otherwise it is 0.
- R11: A low pulse on the line that is back high at the half-bit check eight ticks after the edge yields no character.
- R12: After reset the queue is empty, `rtsN` is 0 and every read output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Oversampling enable, 16 pulses per bit |
| rxSerial | input | 1 | Serial line, idle high |
| charLenSel | input | 2 | Data bits minus five |
| parityOn | input | 1 | Expect a parity bit |
| parityOdd | input | 1 | 1 = odd parity, 0 = even |
| intSelFull | input | 1 | Interrupt source: 1 = full, 0 = ready |
| autoRtsOn | input | 1 | Enable automatic RTS release |
| rdStrobe | input | 1 | Pop the head character |
| rdData | output | 8 | Head character |
| rdParErr | output | 1 | Head parity error |
| rdFrmErr | output | 1 | Head framing error |
| rdOvrErr | output | 1 | Head overrun flag |
| rxReady | output | 1 | At least one character queued |
| queueFull | output | 1 | Three characters queued |
| rxIrq | output | 1 | Selected interrupt condition |
| rtsN | output | 1 | Request to send, active low |

## Verification
The checker watches, on every cycle, the relations between the queue outputs. Fullness implies readiness. Readiness and fullness cannot fall without a read. The head data stay stable while no read occurs. RTS is released whenever automatic mode is on and the queue is full, and the interrupt stays low in full mode while the queue has room. Only the bench scenarios can show that the deframing is right. These cover bit order and length masking, parity sense, framing and overrun flags landing on the right entry, and the rejection of a false start, all compared against a behavioural queue model.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int RXQ_DATA_W = 8;

  typedef struct packed {
    logic frameStart;
    logic dataBit;
    logic parityBit;
    logic stopBit;
    logic lineVal;
  } rxStrobes_t;

  typedef struct packed {
    logic [RXQ_DATA_W-1:0] data;
    logic parErr;
    logic frmErr;
    logic ovrErr;
  } rxEntry_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       rxSerial,
  input  logic [1:0] charLenSel,
  input  logic       parityOn,
  output rxStrobes_t strb
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;
  localparam int BW   = $clog2(RXQ_DATA_W);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} rxState_t;

  rxState_t        state;
  logic [CW-1:0]   tickCnt;
  logic [BW-1:0]   bitIdx;
  logic [BW-1:0]   lastBit;
  logic [SYNC-1:0] syncQ;
  logic            rxS;
  logic            cellEnd;
  logic            halfEnd;

  assign rxS     = syncQ[SYNC-1];
  assign lastBit = BW'(4 + int'(charLenSel));
  assign cellEnd = tickEn && (tickCnt == CW'(OVS - 1));
  assign halfEnd = tickEn && (tickCnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC-2:0], rxSerial};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (tickEn) begin
      unique case (state)
        S_IDLE: begin
          tickCnt <= '0;
          if (!rxS) state <= S_START;
        end
        S_START: begin
          if (halfEnd) begin
            tickCnt <= '0;
            bitIdx  <= '0;
            state   <= rxS ? S_IDLE : S_DATA;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_DATA: begin
          if (cellEnd) begin
            tickCnt <= '0;
            bitIdx  <= bitIdx + 1'b1;
            if (bitIdx == lastBit) state <= parityOn ? S_PAR : S_STOP;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_PAR: begin
          if (cellEnd) begin
            tickCnt <= '0;
            state   <= S_STOP;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_STOP: begin
          if (cellEnd) begin
            tickCnt <= '0;
            state   <= S_IDLE;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.frameStart = halfEnd && (state == S_START) && !rxS;
    strb.dataBit    = cellEnd && (state == S_DATA);
    strb.parityBit  = cellEnd && (state == S_PAR);
    strb.stopBit    = cellEnd && (state == S_STOP);
    strb.lineVal    = rxS;
  end
endmodule

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  rxStrobes_t              strb,
  input  logic [1:0]              charLenSel,
  input  logic                    parityOdd,
  input  logic                    rdStrobe,
  output rxEntry_t                head,
  output logic [$clog2(DEPTH+1)-1:0] fillCnt
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);
  localparam logic [PW-1:0]   LAST_IDX = PW'(DEPTH - 1);

  logic [RXQ_DATA_W-1:0] shiftReg;
  logic                  parAcc;
  logic                  parBad;
  logic [RXQ_DATA_W-1:0] alignedData;
  logic [1:0]            shAmt;

  rxEntry_t        mem [DEPTH];
  logic [PW-1:0]   wrPtr, rdPtr, newestIdx;
  logic            isFull, doPop, doStore, doOverrun;
  rxEntry_t        newEntry;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      parBad   <= 1'b0;
    end else if (strb.frameStart) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      parBad   <= 1'b0;
    end else if (strb.dataBit) begin
      shiftReg <= {strb.lineVal, shiftReg[RXQ_DATA_W-1:1]};
      parAcc   <= parAcc ^ strb.lineVal;
    end else if (strb.parityBit) begin
      parBad   <= parAcc ^ strb.lineVal ^ parityOdd;
    end
  end

  assign shAmt       = 2'd3 - charLenSel;
  assign alignedData = shiftReg >> shAmt;

  always_comb begin
    newEntry.data   = alignedData;
    newEntry.parErr = parBad;
    newEntry.frmErr = !strb.lineVal;
    newEntry.ovrErr = 1'b0;
  end

  assign isFull    = (fillCnt == FULL_CNT);
  assign doPop     = rdStrobe && (fillCnt != '0);
  assign doStore   = strb.stopBit && (!isFull || doPop);
  assign doOverrun = strb.stopBit && isFull && !doPop;
  assign newestIdx = (wrPtr == '0) ? LAST_IDX : wrPtr - 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fillCnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (doStore) begin
        mem[wrPtr] <= newEntry;
        wrPtr      <= nextPtr(wrPtr);
      end
      if (doOverrun) mem[newestIdx].ovrErr <= 1'b1;
      if (doPop) rdPtr <= nextPtr(rdPtr);
      if (doStore && !doPop)      fillCnt <= fillCnt + 1'b1;
      else if (doPop && !doStore) fillCnt <= fillCnt - 1'b1;
    end
  end

  assign head = (fillCnt != '0) ? mem[rdPtr] : '0;
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int OVS   = 16,
  parameter int SYNC  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       rxSerial,
  input  logic [1:0] charLenSel,
  input  logic       parityOn,
  input  logic       parityOdd,
  input  logic       intSelFull,
  input  logic       autoRtsOn,
  input  logic       rdStrobe,
  output logic [7:0] rdData,
  output logic       rdParErr,
  output logic       rdFrmErr,
  output logic       rdOvrErr,
  output logic       rxReady,
  output logic       queueFull,
  output logic       rxIrq,
  output logic       rtsN
);
  localparam int CNTW = $clog2(DEPTH + 1);

  rxStrobes_t      strb;
  rxEntry_t        head;
  logic [CNTW-1:0] fillCnt;

  rxq_ctrl #(.OVS(OVS), .SYNC(SYNC)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .rxSerial   (rxSerial),
    .charLenSel (charLenSel),
    .parityOn   (parityOn),
    .strb       (strb)
  );

  rxq_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .charLenSel (charLenSel),
    .parityOdd  (parityOdd),
    .rdStrobe   (rdStrobe),
    .head       (head),
    .fillCnt    (fillCnt)
  );

  assign rdData    = head.data;
  assign rdParErr  = head.parErr;
  assign rdFrmErr  = head.frmErr;
  assign rdOvrErr  = head.ovrErr;
  assign rxReady   = (fillCnt != '0);
  assign queueFull = (fillCnt == CNTW'(DEPTH));
  assign rxIrq     = intSelFull ? queueFull : rxReady;
  assign rtsN      = autoRtsOn && queueFull;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       rdStrobe,
  input logic       intSelFull,
  input logic       autoRtsOn,
  input logic [7:0] rdData,
  input logic       rxReady,
  input logic       queueFull,
  input logic       rxIrq,
  input logic       rtsN
);
  a_r3_full_has_ready: assert property (@(posedge clk) disable iff (!rstN)
    queueFull |-> rxReady);

  a_r2_ready_held: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && !rdStrobe) |=> rxReady);

  a_r3_full_held: assert property (@(posedge clk) disable iff (!rstN)
    (queueFull && !rdStrobe) |=> queueFull);

  a_r5_head_stable: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && !rdStrobe) |=> $stable(rdData));

  a_r10_rts_released: assert property (@(posedge clk) disable iff (!rstN)
    (autoRtsOn && queueFull) |-> rtsN);

  a_r4_irq_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (intSelFull && !queueFull) |-> !rxIrq);
endmodule

bind serial_rx_queue rxq_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rdStrobe   (rdStrobe),
  .intSelFull (intSelFull),
  .autoRtsOn  (autoRtsOn),
  .rdData     (rdData),
  .rxReady    (rxReady),
  .queueFull  (queueFull),
  .rxIrq      (rxIrq),
  .rtsN       (rtsN)
);

// File: tb/tb_serial_rx_queue.sv
module tb_serial_rx_queue;
  localparam int BIT_CLKS = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       rxSerial = 1'b1;
  logic [1:0] charLenSel = 2'd3;
  logic       parityOn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       intSelFull = 1'b0;
  logic       autoRtsOn = 1'b1;
  logic       rdStrobe = 1'b0;
  logic [7:0] rdData;
  logic       rdParErr, rdFrmErr, rdOvrErr, rxReady, queueFull, rxIrq, rtsN;

  int checks = 0;
  int errors = 0;
  bit settled = 1'b0;
  int tickDiv = 0;

  typedef struct {
    logic [7:0] d;
    bit p;
    bit f;
    bit o;
  } mEnt_t;
  mEnt_t mq[$];

  serial_rx_queue dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .rxSerial(rxSerial),
    .charLenSel(charLenSel), .parityOn(parityOn), .parityOdd(parityOdd),
    .intSelFull(intSelFull), .autoRtsOn(autoRtsOn), .rdStrobe(rdStrobe),
    .rdData(rdData), .rdParErr(rdParErr), .rdFrmErr(rdFrmErr), .rdOvrErr(rdOvrErr),
    .rxReady(rxReady), .queueFull(queueFull), .rxIrq(rxIrq), .rtsN(rtsN)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    tickDiv <= (tickDiv + 1) % 4;
    tickEn  <= (tickDiv == 3);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model compared on every quiet clock
  always @(negedge clk) begin
    if (settled && rstN) begin
      automatic bit full = (mq.size() == 3);
      automatic bit rdy = (mq.size() > 0);
      check(rxReady == rdy, "R2 rxReady", rxReady, rdy);
      check(queueFull == full, "R3 queueFull", queueFull, full);
      check(rxIrq == (intSelFull ? full : rdy), "R4 rxIrq", rxIrq, intSelFull ? full : rdy);
      check(rtsN == (autoRtsOn && full), "R10 rtsN", rtsN, autoRtsOn && full);
      if (rdy) begin
        check(rdData == mq[0].d, "R5 head data", rdData, mq[0].d);
        check({rdParErr, rdFrmErr, rdOvrErr} == {mq[0].p, mq[0].f, mq[0].o},
              "R5 head flags", {rdParErr, rdFrmErr, rdOvrErr}, {mq[0].p, mq[0].f, mq[0].o});
      end else begin
        check({rdData, rdParErr, rdFrmErr, rdOvrErr} == 11'd0, "R5 empty outputs",
              {rdData, rdParErr, rdFrmErr, rdOvrErr}, 0);
      end
    end
  end

  task automatic driveBit(input logic v, input int clks);
    rxSerial = v;
    repeat (clks) @(posedge clk);
    #1;
  endtask

  task automatic sendFrame(input logic [7:0] val, input bit badPar, input bit badStop);
    automatic int len = 5 + int'(charLenSel);
    automatic logic [7:0] mask = 8'((1 << len) - 1);
    automatic logic [7:0] v = val & mask;
    automatic mEnt_t e;
    settled = 1'b0;
    @(posedge clk); #1;
    driveBit(1'b0, BIT_CLKS);
    for (int i = 0; i < len; i++) driveBit(v[i], BIT_CLKS);
    if (parityOn) driveBit((^v) ^ parityOdd ^ badPar, BIT_CLKS);
    driveBit(!badStop, BIT_CLKS);
    driveBit(1'b1, 2 * BIT_CLKS);
    e.d = v; e.p = parityOn && badPar; e.f = badStop; e.o = 1'b0;
    if (mq.size() == 3) mq[2].o = 1'b1;
    else mq.push_back(e);
    settled = 1'b1;
  endtask

  task automatic popOne();
    @(posedge clk); #1;
    rdStrobe = 1'b1;
    @(posedge clk); #1;
    rdStrobe = 1'b0;
    if (mq.size() > 0) void'(mq.pop_front());
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1;
    // R12: reset state
    check(rxReady == 0 && queueFull == 0 && rxIrq == 0, "R12 reset flags",
          {rxReady, queueFull, rxIrq}, 0);
    check(rtsN == 0 && rdData == 0 && {rdParErr, rdFrmErr, rdOvrErr} == 0,
          "R12 reset data", {rtsN, rdData}, 0);
    rstN = 1'b1;
    settled = 1'b1;
    waitClk(20);

    // R6: 8 data bits, no parity
    charLenSel = 2'd3; parityOn = 0;
    sendFrame(8'hA5, 0, 0);
    waitClk(2);
    check(rdData == 8'hA5, "R6 8-bit data", rdData, 8'hA5);
    check(rdParErr == 0, "R7 no parity flag", rdParErr, 0);
    popOne();

    // R6/R7: 5 bits, even parity, correct
    charLenSel = 2'd0; parityOn = 1; parityOdd = 0;
    sendFrame(8'hFF, 0, 0);
    waitClk(2);
    check(rdData == 8'h1F, "R6 5-bit masked", rdData, 8'h1F);
    check(rdParErr == 0, "R7 even parity ok", rdParErr, 0);
    popOne();

    // R7: 7 bits, odd parity, corrupted
    charLenSel = 2'd2; parityOdd = 1;
    sendFrame(8'h55, 1, 0);
    waitClk(2);
    check(rdData == 8'h55, "R6 7-bit data", rdData, 8'h55);
    check(rdParErr == 1, "R7 odd parity error", rdParErr, 1);
    popOne();

    // R7: odd parity, correct
    sendFrame(8'h13, 0, 0);
    waitClk(2);
    check(rdParErr == 0, "R7 odd parity ok", rdParErr, 0);
    popOne();

    // R8: 6 bits, low stop bit
    charLenSel = 2'd1; parityOn = 0;
    sendFrame(8'hEA, 0, 1);
    waitClk(2);
    check(rdData == 8'h2A, "R8 data kept", rdData, 8'h2A);
    check(rdFrmErr == 1, "R8 framing flag", rdFrmErr, 1);
    popOne();
    waitClk(4);
    check(rxReady == 0, "R8 no stray char", rxReady, 0);

    // R1/R3/R4/R10: fill the queue
    charLenSel = 2'd3; intSelFull = 1; autoRtsOn = 1;
    sendFrame(8'h11, 0, 0);
    check(rxIrq == 0, "R4 irq low below full", rxIrq, 0);
    sendFrame(8'h22, 0, 0);
    sendFrame(8'h33, 0, 0);
    waitClk(2);
    check(queueFull == 1, "R3 full at three", queueFull, 1);
    check(rxIrq == 1, "R4 irq on full", rxIrq, 1);
    check(rtsN == 1, "R10 rts released", rtsN, 1);
    autoRtsOn = 0;
    waitClk(2);
    check(rtsN == 0, "R10 rts manual", rtsN, 0);
    autoRtsOn = 1;

    // R9: overrun
    sendFrame(8'h44, 0, 0);
    waitClk(2);
    check(rdData == 8'h11 && rdOvrErr == 0, "R9 head unchanged", {rdOvrErr, rdData}, 8'h11);
    popOne();
    waitClk(2);
    check(rtsN == 0, "R10 rts back", rtsN, 0);
    check(rdData == 8'h22 && rdOvrErr == 0, "R1 second", {rdOvrErr, rdData}, 8'h22);
    popOne();
    waitClk(2);
    check(rdData == 8'h33 && rdOvrErr == 1, "R9 newest flagged", {rdOvrErr, rdData}, 9'h133);
    popOne();
    waitClk(2);
    check(rxReady == 0, "R1 drained, 44 dropped", rxReady, 0);

    // R11: false start glitch
    intSelFull = 0;
    driveBit(1'b0, 8);
    driveBit(1'b1, 4 * BIT_CLKS);
    check(rxReady == 0, "R11 glitch rejected", rxReady, 0);

    // R2/R4: ready-mode interrupt
    sendFrame(8'h7E, 0, 0);
    waitClk(2);
    check(rxIrq == 1, "R4 irq on ready", rxIrq, 1);
    popOne();
    waitClk(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule